// File: doc/BRIEF.md
# Change-Triggered Sample Batching Cache

This block sits between a sensor front end and an uplink path on a duty-cycled node. Each wake cycle delivers one signed sample. The block writes the sample into a small retained buffer and compares it with a stored reference value. A radio uplink is worth its cost only when the reading has moved far enough from that reference, or when the buffer has no room left. Steady readings therefore pile up locally and are not sent one at a time.

When an uplink is due, the block raises a transmit request and sends the buffered samples out over a valid/ready stream. The oldest sample goes first. The batch size is shown with the beats, and the final beat carries a marker. While the stream runs, the sample input is stalled. Once the batch has gone, the reference becomes the sample that started the uplink and the buffer starts filling again from its first slot. A first-boot input makes the sample that comes with it the new reference and empties the buffer before that sample is stored.

Top module: `sample_batcher`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and tx_req is 0.
- R2: A sample accepted with in_first_boot = 1 becomes the reference and is stored in slot 0. Any earlier buffer contents are discarded. Its own difference is zero.
- R3: A sample whose absolute difference from the reference is below in_threshold is stored in the next free slot. It raises no uplink and leaves the reference unchanged.
- R4: A sample whose absolute difference from the reference is greater than or equal to in_threshold starts an uplink, whatever the sign of the difference. in_threshold is an unsigned value one bit wider than the sample.
- R5: A sample that fills the last of the DEPTH slots starts an uplink of all DEPTH samples, even when its difference is small.
- R6: During an uplink, out_valid stays high and the stored samples appear on out_data in write order, starting from slot 0. out_first is 1 only on the first beat and out_last is 1 only on the final beat. out_count equals the batch size and does not change across the beats. out_valid falls after the handshake on the final beat.
- R7: After an uplink, the reference is the sample that started it, and the next accepted sample is stored in slot 0.
- R8: While an uplink is in progress, in_ready is 0 and no offered sample is accepted. While out_ready is 0, out_data and out_valid hold their values.
- R9: Samples are signed two's-complement values. The difference is formed one bit wider than the sample, so opposite extremes compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block can take a sample |
| in_sample | input | DW | Signed sample value |
| in_first_boot | input | 1 | Make this sample the reference and empty the buffer |
| in_threshold | input | DW+1 | Unsigned change threshold |
| tx_req | output | 1 | Uplink in progress |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | DW | Streamed sample |
| out_count | output | CW | Number of samples in the batch |
| out_first | output | 1 | First beat of the batch |
| out_last | output | 1 | Final beat of the batch |

## Verification
The bench builds the block with DW = 4 and DEPTH = 4. With these values every pair of reference and sample, from -8 to 7, can be tried, each with a threshold equal to the absolute difference and with a threshold one above it. This covers both sides of the comparison, both signs of the difference, zero change and the largest swing. The small depth means the full-buffer uplink, the reset of the reference after an uplink and back-pressured streams all come up within a few samples.

// File: rtl/sample_batcher.sv
module sample_batcher #(
  parameter int DW    = 16,
  parameter int DEPTH = 24,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_sample,
  input  logic          in_first_boot,
  input  logic [DW:0]   in_threshold,
  output logic          tx_req,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_count,
  output logic          out_first,
  output logic          out_last
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] base_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rd_q;
  logic          busy_q;

  logic          accept;
  logic [DW-1:0] base_eff;
  logic [CW-1:0] idx_eff;
  logic [DW:0]   diff;
  logic [DW:0]   mag;
  logic          room;
  logic [CW-1:0] idx_next;
  logic          fire;
  logic          beat_done;

  assign accept    = in_valid && !busy_q;
  assign base_eff  = in_first_boot ? in_sample : base_q;
  assign idx_eff   = in_first_boot ? '0 : idx_q;
  assign diff      = {in_sample[DW-1], in_sample} - {base_eff[DW-1], base_eff};
  assign mag       = diff[DW] ? (~diff + 1'b1) : diff;
  assign room      = idx_eff < CW'(DEPTH);
  assign idx_next  = room ? idx_eff + CW'(1) : idx_eff;
  assign fire      = (mag >= in_threshold) || (idx_next == CW'(DEPTH));
  assign beat_done = busy_q && out_ready;

  always_ff @(posedge clk) begin
    if (accept && room)
      mem[idx_eff[AW-1:0]] <= in_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      if (fire) begin
        base_q <= in_sample;
        idx_q  <= '0;
        cnt_q  <= idx_next;
        rd_q   <= '0;
        busy_q <= 1'b1;
      end else begin
        base_q <= base_eff;
        idx_q  <= idx_next;
      end
    end else if (beat_done) begin
      if (rd_q == cnt_q - CW'(1)) begin
        busy_q <= 1'b0;
        rd_q   <= '0;
      end else begin
        rd_q <= rd_q + CW'(1);
      end
    end
  end

  assign in_ready  = !busy_q;
  assign tx_req    = busy_q;
  assign out_valid = busy_q;
  assign out_data  = mem[rd_q[AW-1:0]];
  assign out_count = cnt_q;
  assign out_first = busy_q && (rd_q == '0);
  assign out_last  = busy_q && (rd_q == cnt_q - CW'(1));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid));

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < CW'(DEPTH));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_first_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && !out_first));

  assert_start_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  assert_count_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_count));

  assert_end_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  assert_full_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_first_boot && idx_q == CW'(DEPTH - 1)) |=> out_valid);

endmodule

// File: tb/test_sample_batcher.sv
module test_sample_batcher;
  localparam int DW = 4;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);
  localparam int TMAX = (1 << (DW + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_sample = '0;
  logic in_first_boot = 1'b0;
  logic [DW:0] in_threshold = '0;
  logic tx_req;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_count;
  logic out_first;
  logic out_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int base_m = 0;
  int idx_m = 0;
  int cache_m [D];

  always #4 clk = ~clk;

  sample_batcher #(.DW(DW), .DEPTH(D)) i_sample_batcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_first_boot(in_first_boot), .in_threshold(in_threshold),
    .tx_req(tx_req), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_count(out_count), .out_first(out_first), .out_last(out_last));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic collect(input int cnt, input bit bp, input bit hold_in);
    int beat = 0;
    int guard = 0;
    bit stalled = 1'b0;
    int prev = 0;
    chk(in_ready == 1'b0, "R8 in_ready low while streaming", int'(in_ready), 0);
    chk(tx_req == 1'b1, "R4 tx_req during uplink", int'(tx_req), 1);
    if (hold_in) begin
      in_valid = 1'b1;
      in_sample = 4'(7);
      in_first_boot = 1'b1;
      in_threshold = '0;
    end
    while (beat < cnt && guard < 64) begin
      guard++;
      if (!out_valid) begin
        chk(1'b0, "R6 out_valid held through batch", 0, 1);
        break;
      end
      if (stalled)
        chk(int'($signed(out_data)) == prev, "R8 data held under stall", int'($signed(out_data)), prev);
      out_ready = bp ? (guard % 2 == 0) : 1'b1;
      if (out_ready) begin
        chk(int'($signed(out_data)) == cache_m[beat], "R6 stream order", int'($signed(out_data)), cache_m[beat]);
        chk(out_first == (beat == 0), "R6 first marker", int'(out_first), int'(beat == 0));
        chk(out_last == (beat == cnt - 1), "R6 last marker", int'(out_last), int'(beat == cnt - 1));
        chk(int'(out_count) == cnt, "R6 batch count", int'(out_count), cnt);
        beat++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        prev = int'($signed(out_data));
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    if (hold_in) begin
      in_valid = 1'b0;
      in_first_boot = 1'b0;
    end
    chk(out_valid == 1'b0, "R6 stream ends after last beat", int'(out_valid), 0);
    if (hold_in) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 sample offered during uplink not taken", int'(out_valid), 0);
    end
  endtask

  task automatic send(input int s, input bit fb, input int thr, input bit bp, input bit hold_in);
    int be, ie, ne, d;
    bit fire;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready high when idle", int'(in_ready), 1);
    in_valid = 1'b1;
    in_sample = s[DW-1:0];
    in_first_boot = fb;
    in_threshold = thr[DW:0];
    be = fb ? s : base_m;
    ie = fb ? 0 : idx_m;
    ne = ie;
    if (ie < D) begin
      cache_m[ie] = s;
      ne = ie + 1;
    end
    d = (s > be) ? s - be : be - s;
    fire = (d >= thr) || (ne == D);
    @(negedge clk);
    in_valid = 1'b0;
    in_first_boot = 1'b0;
    if (fire) begin
      chk(out_valid == 1'b1, "R4/R5 uplink started", int'(out_valid), 1);
      base_m = s;
      idx_m = 0;
      if (out_valid) collect(ne, bp, hold_in);
    end else begin
      chk(out_valid == 1'b0 && tx_req == 1'b0, "R3/R2 no uplink below threshold", int'(out_valid), 0);
      base_m = be;
      idx_m = ne;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(tx_req == 1'b0, "R1 reset tx_req", int'(tx_req), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R9: every reference/sample pair, threshold at and above the difference
    for (int b = -8; b < 8; b++) begin
      for (int s = -8; s < 8; s++) begin
        for (int t = 0; t < 2; t++) begin
          int d = (s > b) ? s - b : b - s;
          send(b, 1'b1, TMAX, 1'b0, 1'b0);
          send(s, 1'b0, d + t, b[0], 1'b0);
        end
      end
    end

    // R5: filling the buffer with unchanged readings
    send(0, 1'b1, TMAX, 1'b0, 1'b0);
    for (int i = 1; i < D; i++) send(i, 1'b0, TMAX, 1'b1, 1'b0);

    // R7: reference follows the sample that started the uplink
    send(4, 1'b0, 2, 1'b0, 1'b0);
    send(5, 1'b0, 2, 1'b0, 1'b0);
    send(5, 1'b0, 1, 1'b0, 1'b0);
    send(-3, 1'b0, 8, 1'b0, 1'b0);
    send(6, 1'b0, 8, 1'b1, 1'b0);

    // R8: a sample held on the input during an uplink is refused
    send(-8, 1'b1, TMAX, 1'b0, 1'b0);
    send(7, 1'b0, 15, 1'b1, 1'b1);
    send(7, 1'b0, 1, 1'b0, 1'b0);
    send(-1, 1'b0, 8, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule